// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block arbitrates among eight interrupt request lines and presents the winning line, and a vector base, to a processor. Software programs it through a byte-wide register port with one address bit. Writes to the low address either start an initialization sequence or issue a command: a mode control word or an end-of-interrupt or rotation command. Writes to the high address feed the initialization steps or load the mask. Reads return the mask, the request register, the in-service register, or a poll result.

Request bits come in already latched, one set strobe per line per cycle. Priority is measured as an offset from a programmable rotation base, with offset 0 the highest. A request is raised only when its offset is strictly smaller than the offset of the highest in-service line. Interrupts are retired by an acknowledge strobe, by auto end-of-interrupt, by one of the end-of-interrupt commands, or by a poll read, which acknowledges and retires in one step.

Top module: `pic8_top`

## Requirements
- R1: After reset, and after any write to address 0 with data bit 4 set, the request, in-service and mask registers are 0. The rotation base, vector base, poll flag, read select, auto-EOI and rotate flags are also 0, and intReq is low. That write records data bit 0 as "mode word follows" and moves to the first init step.
- R2: During init, the first address-1 write sets vectorBase to the data with bits 2:0 cleared. The second has no effect. A third follows only if the "mode word follows" flag is set, and its bit 1 enables auto end-of-interrupt. None of these writes touches the mask, and vectorBase bits 2:0 are always 0.
- R3: Outside init, an address-1 write loads the mask. A read of address 1 returns the mask when poll is not armed.
- R4: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 = 1 arms poll. Bit 1 = 1 copies bit 0 into the read select, and address-0 reads then return the in-service register when the select is 1 or the request register when it is 0.
- R5: Pending lines are request AND NOT mask. Line L has level (L - base) mod 8, and the pending line with the smallest level is the one reported on intLine.
- R6: intReq is high exactly when the best pending level is strictly smaller than the best in-service level, with an empty set counting as level 8. It follows the registers combinationally.
- R7: An acknowledge while intReq is high clears the request bit of intLine and, without auto-EOI, sets its in-service bit. An acknowledge while intReq is low has no effect.
- R8: With auto-EOI, an acknowledge leaves the in-service register unchanged. If the rotate flag is also set, the rotation base becomes line+1 mod 8. Command code 4 in bits 7:5 (bits 4:3 zero) sets the rotate flag, and code 0 clears it.
- R9: Command code 1 clears the in-service bit with the best level, if any. Code 5 does the same and then sets the base to that line+1 mod 8.
- R10: Code 3 clears the in-service bit named by data bits 2:0. Code 7 does that and sets the base to that line+1. Code 6 sets the base to data bits 2:0 plus 1 mod 8. Code 2 has no effect.
- R11: When poll is armed, a read at either address returns the winning line in bits 2:0 with bits 7:3 zero, or 7 if intReq is low. A winning line has its request and in-service bits cleared. Any read disarms poll.
- R12: Only one operation takes effect per cycle, with a write first, then a read, then an acknowledge. reqSet bits are ORed into the request register after that cycle's clears, so a set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqSet | input | 8 | Per-line request set strobes |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only with poll) |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| ackStrobe | input | 1 | Interrupt acknowledge |
| intReq | output | 1 | Interrupt request to the processor |
| intLine | output | 3 | Winning line number |
| vectorBase | output | 8 | Programmed vector base |

## Verification
Some properties are checked on every cycle. A raised request must name a pending, unmasked line whose in-service bit is clear. An init write must leave all three registers empty. An acknowledge must drop the request bit it served. Idle cycles must leave the registers unchanged, and request strobes must always land. Rotation arithmetic, the nonspecific, specific and rotating retire commands, auto-EOI rotation, the init step sequence and the poll result are value-dependent, so the bench's behavioural model and its directed scenarios cover them.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam int LVLW  = IDXW + 1;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_MODE = 2'd3
  } initStep_t;

  // Strobes from control to datapath, at most one operation per cycle
  typedef struct packed {
    logic            initClr;
    logic            maskLoad;
    logic            irrClr;
    logic            isrClr;
    logic            isrSet;
    logic            baseLoad;
    logic [IDXW-1:0] line;
    logic [IDXW-1:0] baseVal;
  } dpCmd_t;
endpackage

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  input  logic [W-1:0] base,
  output logic [W:0]   level,
  output logic [W-1:0] line
);
  logic [W-1:0] idx;

  // Descending scan so the smallest offset is assigned last
  always_comb begin
    level = (W+1)'(N);
    line  = '0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = base + W'(k);
      if (bits[idx]) begin
        level = (W+1)'(k);
        line  = idx;
      end
    end
  end
endmodule

// File: rtl/pic8_dp.sv
module pic8_dp import pic8_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [LINES-1:0] reqSet,
  input  logic [LINES-1:0] wrData,
  input  logic             readSel,
  input  logic             pollArm,
  input  logic             addr,
  output logic [LINES-1:0] irrQ,
  output logic [LINES-1:0] isrQ,
  output logic [LINES-1:0] imrQ,
  output logic             intReq,
  output logic [IDXW-1:0]  intLine,
  output logic             isrTopValid,
  output logic [IDXW-1:0]  isrTopLine,
  output logic [LINES-1:0] rdData
);
  logic [IDXW-1:0]  baseQ;
  logic [LVLW-1:0]  pendLvl, isrLvl;
  logic [LINES-1:0] irrNext, isrNext, imrNext;
  logic [IDXW-1:0]  baseNext;

  pic8_prio #(.N(LINES), .W(IDXW)) uPend (
    .bits(irrQ & ~imrQ), .base(baseQ), .level(pendLvl), .line(intLine));
  pic8_prio #(.N(LINES), .W(IDXW)) uServ (
    .bits(isrQ), .base(baseQ), .level(isrLvl), .line(isrTopLine));

  assign intReq      = pendLvl < isrLvl;
  assign isrTopValid = isrLvl != LVLW'(LINES);

  always_comb begin
    irrNext  = irrQ;
    isrNext  = isrQ;
    imrNext  = imrQ;
    baseNext = baseQ;
    if (cmd.initClr) begin
      irrNext  = '0;
      isrNext  = '0;
      imrNext  = '0;
      baseNext = '0;
    end
    if (cmd.maskLoad) imrNext = wrData;
    if (cmd.irrClr)   irrNext[cmd.line] = 1'b0;
    if (cmd.isrClr)   isrNext[cmd.line] = 1'b0;
    if (cmd.isrSet)   isrNext[cmd.line] = 1'b1;
    if (cmd.baseLoad) baseNext = cmd.baseVal;
    irrNext = irrNext | reqSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ  <= '0;
      isrQ  <= '0;
      imrQ  <= '0;
      baseQ <= '0;
    end else begin
      irrQ  <= irrNext;
      isrQ  <= isrNext;
      imrQ  <= imrNext;
      baseQ <= baseNext;
    end
  end

  always_comb begin
    if (pollArm)
      rdData = {{(LINES-IDXW){1'b0}}, (intReq ? intLine : IDXW'(LINES-1))};
    else if (addr)
      rdData = imrQ;
    else
      rdData = readSel ? isrQ : irrQ;
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl import pic8_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             ackStrobe,
  input  logic             addr,
  input  logic [LINES-1:0] wrData,
  input  logic             intReq,
  input  logic [IDXW-1:0]  intLine,
  input  logic             isrTopValid,
  input  logic [IDXW-1:0]  isrTopLine,
  output dpCmd_t           cmd,
  output logic             readSel,
  output logic             pollArm,
  output logic [LINES-1:0] vectorBase
);
  initStep_t       stepQ;
  logic            modeWordQ, autoEoiQ, rotAeoiQ;
  logic [2:0]      opCode;
  logic [IDXW-1:0] dataLine;

  assign opCode   = wrData[7:5];
  assign dataLine = wrData[IDXW-1:0];

  always_comb begin
    cmd = '0;
    if (wrEn) begin
      if (!addr) begin
        if (wrData[4]) begin
          cmd.initClr = 1'b1;
        end else if (!wrData[3]) begin
          unique case (opCode)
            3'd1, 3'd5: begin
              cmd.isrClr   = isrTopValid;
              cmd.line     = isrTopLine;
              cmd.baseLoad = isrTopValid && (opCode == 3'd5);
              cmd.baseVal  = isrTopLine + IDXW'(1);
            end
            3'd3: begin
              cmd.isrClr = 1'b1;
              cmd.line   = dataLine;
            end
            3'd6: begin
              cmd.baseLoad = 1'b1;
              cmd.baseVal  = dataLine + IDXW'(1);
            end
            3'd7: begin
              cmd.isrClr   = 1'b1;
              cmd.line     = dataLine;
              cmd.baseLoad = 1'b1;
              cmd.baseVal  = dataLine + IDXW'(1);
            end
            default: ;
          endcase
        end
      end else if (stepQ == STEP_IDLE) begin
        cmd.maskLoad = 1'b1;
      end
    end else if (rdEn) begin
      if (pollArm && intReq) begin
        cmd.irrClr = 1'b1;
        cmd.isrClr = 1'b1;
        cmd.line   = intLine;
      end
    end else if (ackStrobe && intReq) begin
      cmd.irrClr   = 1'b1;
      cmd.line     = intLine;
      cmd.isrSet   = !autoEoiQ;
      cmd.baseLoad = autoEoiQ && rotAeoiQ;
      cmd.baseVal  = intLine + IDXW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ      <= STEP_IDLE;
      modeWordQ  <= 1'b0;
      autoEoiQ   <= 1'b0;
      rotAeoiQ   <= 1'b0;
      readSel    <= 1'b0;
      pollArm    <= 1'b0;
      vectorBase <= '0;
    end else if (wrEn) begin
      if (!addr) begin
        if (wrData[4]) begin
          stepQ      <= STEP_BASE;
          modeWordQ  <= wrData[0];
          autoEoiQ   <= 1'b0;
          rotAeoiQ   <= 1'b0;
          readSel    <= 1'b0;
          pollArm    <= 1'b0;
          vectorBase <= '0;
        end else if (wrData[3]) begin
          if (wrData[2]) pollArm <= 1'b1;
          if (wrData[1]) readSel <= wrData[0];
        end else begin
          if (opCode == 3'd0) rotAeoiQ <= 1'b0;
          if (opCode == 3'd4) rotAeoiQ <= 1'b1;
        end
      end else begin
        unique case (stepQ)
          STEP_BASE: begin
            vectorBase <= {wrData[LINES-1:IDXW], {IDXW{1'b0}}};
            stepQ      <= STEP_SKIP;
          end
          STEP_SKIP: stepQ <= modeWordQ ? STEP_MODE : STEP_IDLE;
          STEP_MODE: begin
            autoEoiQ <= wrData[1];
            stepQ    <= STEP_IDLE;
          end
          default: ;
        endcase
      end
    end else if (rdEn) begin
      pollArm <= 1'b0;
    end
  end
endmodule

// File: rtl/pic8_top.sv
module pic8_top import pic8_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqSet,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [LINES-1:0] wrData,
  output logic [LINES-1:0] rdData,
  input  logic             ackStrobe,
  output logic             intReq,
  output logic [IDXW-1:0]  intLine,
  output logic [LINES-1:0] vectorBase
);
  dpCmd_t           cmd;
  logic             readSel, pollArm, isrTopValid;
  logic [IDXW-1:0]  isrTopLine;
  logic [LINES-1:0] irrQ, isrQ, imrQ;

  pic8_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .ackStrobe(ackStrobe),
    .addr(addr), .wrData(wrData), .intReq(intReq), .intLine(intLine),
    .isrTopValid(isrTopValid), .isrTopLine(isrTopLine), .cmd(cmd),
    .readSel(readSel), .pollArm(pollArm), .vectorBase(vectorBase));

  pic8_dp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqSet(reqSet), .wrData(wrData),
    .readSel(readSel), .pollArm(pollArm), .addr(addr), .irrQ(irrQ),
    .isrQ(isrQ), .imrQ(imrQ), .intReq(intReq), .intLine(intLine),
    .isrTopValid(isrTopValid), .isrTopLine(isrTopLine), .rdData(rdData));
endmodule

// File: rtl/pic8_checker.sv
module pic8_checker import pic8_pkg::*; (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             ackStrobe,
  input logic             addr,
  input logic [LINES-1:0] wrData,
  input logic [LINES-1:0] reqSet,
  input logic             intReq,
  input logic [IDXW-1:0]  intLine,
  input logic [LINES-1:0] vectorBase,
  input logic [LINES-1:0] irrQ,
  input logic [LINES-1:0] isrQ,
  input logic [LINES-1:0] imrQ
);
  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4] && reqSet == '0)
      |=> (irrQ == '0 && isrQ == '0 && imrQ == '0 && !intReq));

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    vectorBase[IDXW-1:0] == '0);

  // R5
  win_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (irrQ[intLine] && !imrQ[intLine]));

  // R6
  strict_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> !isrQ[intLine]);

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intReq && !wrEn && !rdEn && reqSet == '0)
      |=> !irrQ[$past(intLine)]);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn && !ackStrobe && reqSet == '0)
      |=> ($stable(irrQ) && $stable(isrQ) && $stable(imrQ)));

  // R12
  req_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqSet != '0) |=> ((irrQ & $past(reqSet)) == $past(reqSet)));
endmodule

bind pic8_top pic8_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .ackStrobe(ackStrobe),
  .addr(addr), .wrData(wrData), .reqSet(reqSet), .intReq(intReq),
  .intLine(intLine), .vectorBase(vectorBase), .irrQ(irrQ), .isrQ(isrQ),
  .imrQ(imrQ));

// File: tb/sim_pic8_top.sv
module sim_pic8_top;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqSet = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0, ackStrobe = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       intReq;
  logic [2:0] intLine;
  logic [7:0] vectorBase;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic8_top u0 (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ackStrobe(ackStrobe),
    .intReq(intReq), .intLine(intLine), .vectorBase(vectorBase));

  // Behavioural reference state
  bit [7:0] mIrr, mIsr, mImr, mVec;
  int       mBase, mStep;
  bit       mModeWord, mAeoi, mRot, mSel, mPoll;

  function automatic int lvl(bit [7:0] m);
    for (int k = 0; k < 8; k++)
      if (m[(mBase + k) % 8]) return k;
    return 8;
  endfunction

  function automatic bit expReq();
    return lvl(mIrr & ~mImr) < lvl(mIsr);
  endfunction

  function automatic int expLine();
    return (lvl(mIrr & ~mImr) + mBase) % 8;
  endfunction

  function automatic int expRd();
    if (mPoll) return expReq() ? expLine() : 7;
    if (addr) return mImr;
    return mSel ? mIsr : mIrr;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int c, w, p, ln;
    if (!rstN) begin
      mIrr = 0; mIsr = 0; mImr = 0; mVec = 0; mBase = 0; mStep = 0;
      mModeWord = 0; mAeoi = 0; mRot = 0; mSel = 0; mPoll = 0;
    end else begin
      if (wrEn) begin
        if (!addr) begin
          if (wrData[4]) begin
            mIrr = 0; mIsr = 0; mImr = 0; mVec = 0; mBase = 0; mStep = 1;
            mModeWord = wrData[0]; mAeoi = 0; mRot = 0; mSel = 0; mPoll = 0;
          end else if (wrData[3]) begin
            if (wrData[2]) mPoll = 1;
            if (wrData[1]) mSel = wrData[0];
          end else begin
            c = int'(wrData[7:5]);
            w = int'(wrData[2:0]);
            case (c)
              0: mRot = 0;
              4: mRot = 1;
              1, 5: begin
                p = lvl(mIsr);
                if (p < 8) begin
                  ln = (p + mBase) % 8;
                  mIsr[ln] = 0;
                  if (c == 5) mBase = (ln + 1) % 8;
                end
              end
              3: mIsr[w] = 0;
              6: mBase = (w + 1) % 8;
              7: begin mIsr[w] = 0; mBase = (w + 1) % 8; end
              default: ;
            endcase
          end
        end else begin
          case (mStep)
            0: mImr = wrData;
            1: begin mVec = wrData & 8'hF8; mStep = 2; end
            2: mStep = mModeWord ? 3 : 0;
            default: begin mAeoi = wrData[1]; mStep = 0; end
          endcase
        end
      end else if (rdEn) begin
        if (mPoll && expReq()) begin
          ln = expLine();
          mIrr[ln] = 0;
          mIsr[ln] = 0;
        end
        mPoll = 0;
      end else if (ackStrobe && expReq()) begin
        ln = expLine();
        mIrr[ln] = 0;
        if (mAeoi) begin
          if (mRot) mBase = (ln + 1) % 8;
        end else begin
          mIsr[ln] = 1;
        end
      end
      mIrr = mIrr | reqSet;
    end
  end

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      check("R6 model intReq", int'(intReq), int'(expReq()));
      if (expReq()) check("R5 model intLine", int'(intLine), expLine());
      check("R11 model rdData", int'(rdData), expRd());
      check("R2 model vectorBase", int'(vectorBase), int'(mVec));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nChecks++;
      nFails++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic cyc(input logic w, input logic a, input logic ad,
                     input logic [7:0] d, input logic [7:0] rq);
    @(negedge clk); #1;
    wrEn = w; ackStrobe = a; addr = ad; wrData = d; reqSet = rq;
    @(negedge clk); #1;
    wrEn = 0; ackStrobe = 0; addr = 0; wrData = 0; reqSet = 0;
  endtask

  task automatic wr(input logic ad, input logic [7:0] d);
    cyc(1'b1, 1'b0, ad, d, 8'h00);
  endtask

  task automatic req(input logic [7:0] rq);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, rq);
  endtask

  task automatic ack();
    cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic rd(input logic ad, output logic [7:0] v);
    @(negedge clk); #1;
    rdEn = 1; addr = ad;
    #2 v = rdData;
    @(negedge clk); #1;
    rdEn = 0; addr = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check("R1 reset intReq", int'(intReq), 0);
    check("R1 reset vectorBase", int'(vectorBase), 0);
    rd(1'b1, v); check("R1 reset mask", int'(v), 0);
    rd(1'b0, v); check("R1 reset request reg", int'(v), 0);

    // R2 init sequence with mode word
    wr(0, 8'h11); wr(1, 8'h45); wr(1, 8'hFF); wr(1, 8'h00);
    check("R2 vector base", int'(vectorBase), 8'h40);
    rd(1'b1, v); check("R2 init steps leave mask", int'(v), 0);

    // R3 mask load and readback
    wr(1, 8'hF0);
    rd(1'b1, v); check("R3 mask readback", int'(v), 8'hF0);

    // R5 masked requests stay silent, unmasked lowest offset wins
    req(8'h30);
    check("R5 masked lines", int'(intReq), 0);
    req(8'h0A);
    check("R5 winner line", int'(intLine), 1);
    check("R5 winner raised", int'(intReq), 1);

    // R4 read select of request register
    wr(0, 8'h0A);
    rd(1'b0, v); check("R4 request reg read", int'(v), 8'h3A);

    // R7 acknowledge moves line 1 to service; R6 lower line blocked
    ack();
    check("R6 lower level blocked", int'(intReq), 0);
    wr(0, 8'h0B);
    rd(1'b0, v); check("R7 in-service after ack", int'(v), 8'h02);

    // R6 higher level preempts
    req(8'h01);
    check("R6 preempt raised", int'(intReq), 1);
    check("R6 preempt line", int'(intLine), 0);

    // R9 nonspecific EOI clears the best in-service bit
    ack();
    wr(0, 8'h20);
    rd(1'b0, v); check("R9 nonspecific EOI", int'(v), 8'h02);

    // R9 rotating EOI: clears line 1, base 2
    wr(0, 8'hA0);
    check("R9 rotating EOI line", int'(intLine), 3);
    req(8'h06);
    check("R9 rotated priority", int'(intLine), 2);

    // R10 set base via code 6, base 4
    wr(0, 8'hC3);
    check("R10 base set line", int'(intLine), 1);
    wr(0, 8'h40);
    check("R10 code 2 no effect line", int'(intLine), 1);
    rd(1'b0, v); check("R10 code 2 no effect isr", int'(v), 0);

    // R10 specific EOI
    ack();
    check("R10 service blocks", int'(intReq), 0);
    wr(0, 8'h61);
    check("R10 specific EOI raised", int'(intReq), 1);
    check("R10 specific EOI line", int'(intLine), 2);

    // R10 specific rotating EOI
    ack();
    wr(0, 8'hE2);
    check("R10 specific rotate line", int'(intLine), 3);

    // R11 poll reads
    wr(0, 8'h0C);
    rd(1'b1, v); check("R11 poll winner", int'(v), 3);
    check("R11 poll retired", int'(intReq), 0);
    wr(0, 8'h0C);
    rd(1'b0, v); check("R11 poll none", int'(v), 7);
    rd(1'b1, v); check("R11 poll disarmed", int'(v), 8'hF0);

    // R1 re-init clears; R2 mode word enables auto-EOI
    wr(0, 8'h13);
    check("R1 init intReq", int'(intReq), 0);
    check("R1 init vector", int'(vectorBase), 0);
    rd(1'b1, v); check("R1 init mask", int'(v), 0);
    wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h02);
    check("R2 second vector", int'(vectorBase), 8'h08);

    // R8 auto-EOI with rotation
    req(8'h20);
    check("R8 line 5 raised", int'(intLine), 5);
    wr(0, 8'h80);
    ack();
    wr(0, 8'h0B);
    rd(1'b0, v); check("R8 no in-service", int'(v), 0);
    req(8'h21);
    check("R8 rotated after ack", int'(intLine), 0);

    // R12 simultaneous set wins over acknowledge clear
    cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'h01);
    wr(0, 8'h0A);
    rd(1'b0, v); check("R12 set wins", int'(v), 8'h21);
    check("R12 base after ack", int'(intLine), 5);

    // R12 write takes priority over acknowledge
    cyc(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    rd(1'b0, v); check("R12 ack ignored under write", int'(v), 8'h21);
    check("R12 line unchanged", int'(intLine), 5);

    // R7 acknowledge with no request is ignored
    wr(1, 8'hFF);
    ack();
    wr(1, 8'h00);
    rd(1'b0, v); check("R7 idle ack ignored", int'(v), 8'h21);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule